// File: doc/BRIEF.md
# Dual-Rail Weak-Condition Half Buffer

This block is a single-slot, one-bit pipeline stage that speaks a four-phase dual-rail handshake on both sides. A sender presents a bit on two wires, one for zero and one for one. The stage copies that bit onto its own pair of output wires when the downstream receiver is ready. It then acknowledges the sender by dropping its input enable. When the receiver has taken the bit and the sender has gone back to neutral, the stage returns to empty.

The handshake is modelled as a clocked state machine. Every step takes one clock after the stage sees the condition that allows it. A parameter picks the reset flavour. With `INIT_TOKEN = 0` the stage starts empty, and its output return and input re-enable happen together as one step. With `INIT_TOKEN = 1` the stage starts out holding a zero token, and the two halves of the return to empty run independently of each other.

Top module: `dr_wchb_buf`

## Requirements
- R1: The output pair is never both high. The output codes are: both low means empty, `out_f` high means a zero, `out_t` high means a one.
- R2: When `in_en` is high, the output pair is empty, `out_en` is high and exactly one input rail is high, the following conditions hold one clock later. The output rail matching the input rail is high: `in_f` maps to `out_f` and `in_t` maps to `out_t`. In the same cycle `in_en` is low.
- R3: With `INIT_TOKEN = 0`, a held output falls and `in_en` rises in the same clock edge. That edge is the first one at which `out_en` is low and both input rails are low. Neither change happens before then.
- R4: With `INIT_TOKEN = 1`, a held output pair falls one clock after `out_en` is seen low, whatever the input rails are. A low `in_en` rises one clock after both input rails are seen low, whatever `out_en` is. No new transfer starts while the output still holds a token.
- R5: With `INIT_TOKEN = 0`, reset leaves `out_f = 0`, `out_t = 0` and `in_en = 1`.
- R6: With `INIT_TOKEN = 1`, reset leaves `out_f = 1`, `out_t = 0` and `in_en = 1`. The stage holds a zero token.
- R7: With `INIT_TOKEN = 0`, no transfer happens after reset until one clock edge has seen `out_en` high and both input rails low at once.
- R8: While both input rails are high, `out_f`, `out_t` and `in_en` keep their values.
- R9: Under a four-phase source and a four-phase sink, the bits delivered equal the bits sent, in order. They follow the zero token when `INIT_TOKEN = 1`.
- R10: Reset is synchronous and active-high. While `rst` is high, the outputs hold their reset values whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_f | input | 1 | Input zero rail from the sender |
| in_t | input | 1 | Input one rail from the sender |
| in_en | output | 1 | Enable back to the sender, high when the stage will accept |
| out_f | output | 1 | Output zero rail to the receiver |
| out_t | output | 1 | Output one rail to the receiver |
| out_en | input | 1 | Enable from the receiver, high when it will accept |

## Verification
The bench builds two copies side by side: `u0` with `INIT_TOKEN = 0` and `u1` with `INIT_TOKEN = 1`. The empty-reset copy is used to check the joint return to empty and the wait for the first neutral input after reset. The token-reset copy is used to check the preloaded zero and the two independent halves of the return. This includes the case where the output drains while the input is still valid, and the reverse case. Both copies then stream random bits between a four-phase source and a four-phase sink with random stalls, so that token order is compared with and without the preloaded token.

// File: rtl/dr_buf_pkg.sv
`timescale 1ns/1ps
package dr_buf_pkg;

  // One dual-rail digit; f is the zero rail, t the one rail.
  typedef struct packed {
    logic f;
    logic t;
  } rail_pair_t;

  // Code of a rail pair, indexed as {t, f}.
  typedef enum logic [1:0] {
    RC_NEUTRAL = 2'b00,
    RC_ZERO    = 2'b01,
    RC_ONE     = 2'b10,
    RC_BAD     = 2'b11
  } rail_code_e;

  function automatic rail_code_e classify(input rail_pair_t p);
    return rail_code_e'({p.t, p.f});
  endfunction

endpackage

// File: rtl/dr_rail_decode.sv
`timescale 1ns/1ps
module dr_rail_decode
  import dr_buf_pkg::*;
(
  input  rail_pair_t rails,
  output logic       valid,
  output logic       neutral,
  output logic       illegal,
  output logic       value
);

  rail_code_e code;
  assign code = classify(rails);

  always_comb begin
    valid   = 1'b0;
    neutral = 1'b0;
    illegal = 1'b0;
    value   = 1'b0;
    unique case (code)
      RC_NEUTRAL: neutral = 1'b1;
      RC_ZERO:    valid   = 1'b1;
      RC_ONE: begin
        valid = 1'b1;
        value = 1'b1;
      end
      RC_BAD:     illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/dr_hs_ctrl.sv
`timescale 1ns/1ps
module dr_hs_ctrl
  import dr_buf_pkg::*;
#(
  parameter int INIT_TOKEN = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_neutral,
  input  logic       in_illegal,
  input  logic       in_value,
  input  logic       out_en,
  output rail_pair_t out_rails,
  output logic       in_en
);

  localparam logic       PRELOAD   = (INIT_TOKEN != 0);
  localparam rail_pair_t RST_RAILS = '{f: PRELOAD, t: 1'b0};

  rail_pair_t out_q;
  logic       in_en_q;
  logic       out_busy;
  logic       primed;
  logic       fire;
  logic       drain_out;
  logic       reopen_in;

  assign out_busy = out_q.f | out_q.t;

  // Forward step: empty stage, sender valid, receiver ready.
  assign fire = in_en_q & ~out_busy & out_en & in_valid & ~in_illegal & primed;

  generate
    if (INIT_TOKEN == 0) begin : g_joint
      logic primed_q;
      // First pass through the loop waits for a ready, neutral environment.
      always_ff @(posedge clk) begin
        if (rst) begin
          primed_q <= 1'b0;
        end else if (out_en && in_neutral) begin
          primed_q <= 1'b1;
        end
      end
      assign primed    = primed_q;
      // Output return and input re-enable form one step.
      assign drain_out = out_busy & ~in_en_q & ~out_en & in_neutral;
      assign reopen_in = drain_out;
    end else begin : g_split
      assign primed    = 1'b1;
      // Two independent branches; the stage is empty once both are done.
      assign drain_out = out_busy & ~out_en & ~in_illegal;
      assign reopen_in = ~in_en_q & in_neutral;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= RST_RAILS;
      in_en_q <= 1'b1;
    end else if (fire) begin
      out_q.f <= ~in_value;
      out_q.t <= in_value;
      in_en_q <= 1'b0;
    end else begin
      if (drain_out) begin
        out_q <= '0;
      end
      if (reopen_in) begin
        in_en_q <= 1'b1;
      end
    end
  end

  assign out_rails = out_q;
  assign in_en     = in_en_q;

endmodule

// File: rtl/dr_wchb_buf.sv
`timescale 1ns/1ps
module dr_wchb_buf
  import dr_buf_pkg::*;
#(
  parameter int INIT_TOKEN = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic in_f,
  input  logic in_t,
  output logic in_en,
  output logic out_f,
  output logic out_t,
  input  logic out_en
);

  rail_pair_t in_rails;
  rail_pair_t out_rails;
  logic       in_valid;
  logic       in_neutral;
  logic       in_illegal;
  logic       in_value;

  assign in_rails = '{f: in_f, t: in_t};

  dr_rail_decode u_dec (
    .rails   (in_rails),
    .valid   (in_valid),
    .neutral (in_neutral),
    .illegal (in_illegal),
    .value   (in_value)
  );

  dr_hs_ctrl #(
    .INIT_TOKEN (INIT_TOKEN)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_neutral (in_neutral),
    .in_illegal (in_illegal),
    .in_value   (in_value),
    .out_en     (out_en),
    .out_rails  (out_rails),
    .in_en      (in_en)
  );

  assign out_f = out_rails.f;
  assign out_t = out_rails.t;

endmodule

// File: rtl/dr_wchb_chk.sv
`timescale 1ns/1ps
module dr_wchb_chk #(
  parameter int INIT_TOKEN = 0
) (
  input logic clk,
  input logic rst,
  input logic in_f,
  input logic in_t,
  input logic in_en,
  input logic out_f,
  input logic out_t,
  input logic out_en
);

  // R1
  out_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_f && out_t));

  // R2
  rise_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_f) |-> $past(in_f && !in_t && out_en && in_en));

  // R2
  rise_one_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_t) |-> $past(in_t && !in_f && out_en && in_en));

  // R2
  ack_order_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(in_en) |-> ($rose(out_f) || $rose(out_t)));

  // R3 R4
  drain_order_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_f || out_t) |-> $past(!out_en));

  // R3 R4
  reopen_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_en) |-> $past(!in_f && !in_t));

  // R8
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_f && in_t) |=> $stable({out_f, out_t, in_en}));

  generate
    if (INIT_TOKEN == 0) begin : g_joint_chk
      // R3
      joint_step_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_en) |-> $fell(out_f || out_t));
    end
  endgenerate

endmodule

bind dr_wchb_buf dr_wchb_chk #(.INIT_TOKEN(INIT_TOKEN)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .in_f   (in_f),
  .in_t   (in_t),
  .in_en  (in_en),
  .out_f  (out_f),
  .out_t  (out_t),
  .out_en (out_en)
);

// File: tb/sim_dr_wchb_buf.sv
`timescale 1ns/1ps
module sim_dr_wchb_buf;

  localparam int NTOK = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_if = 1'b0, a_it = 1'b0, a_oe = 1'b0;
  logic b_if = 1'b0, b_it = 1'b0, b_oe = 1'b0;
  logic a_ie, a_of, a_ot, b_ie, b_of, b_ot;
  int   checks = 0;
  int   errors = 0;
  logic qa[$];
  logic qb[$];

  always #2.5 clk = ~clk;

  dr_wchb_buf #(.INIT_TOKEN(0)) u0 (
    .clk(clk), .rst(rst), .in_f(a_if), .in_t(a_it), .in_en(a_ie),
    .out_f(a_of), .out_t(a_ot), .out_en(a_oe));

  dr_wchb_buf #(.INIT_TOKEN(1)) u1 (
    .clk(clk), .rst(rst), .in_f(b_if), .in_t(b_it), .in_en(b_ie),
    .out_f(b_of), .out_t(b_ot), .out_en(b_oe));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk3(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b exp %b", req, got, exp);
    end
  endtask

  task automatic src_a(input int n);
    for (int i = 0; i < n; i++) begin
      logic v;
      do @(negedge clk); while (!a_ie);
      repeat ($urandom % 3) @(negedge clk);
      v = 1'($urandom);
      qa.push_back(v);
      a_if = !v;
      a_it = v;
      do @(negedge clk); while (a_ie);
      repeat ($urandom % 2) @(negedge clk);
      a_if = 1'b0;
      a_it = 1'b0;
    end
  endtask

  task automatic src_b(input int n);
    for (int i = 0; i < n; i++) begin
      logic v;
      do @(negedge clk); while (!b_ie);
      repeat ($urandom % 3) @(negedge clk);
      v = 1'($urandom);
      qb.push_back(v);
      b_if = !v;
      b_it = v;
      do @(negedge clk); while (b_ie);
      repeat ($urandom % 2) @(negedge clk);
      b_if = 1'b0;
      b_it = 1'b0;
    end
  endtask

  task automatic snk_a(input int n);
    int got = 0;
    while (got < n) begin
      @(negedge clk);
      if (a_oe && (a_of || a_ot)) begin
        if (qa.size() == 0) chk3("R9 u0 unexpected token", {2'b0, a_ot}, 3'bxxx);
        else chk3("R9 u0 token order", {2'b0, a_ot}, {2'b0, qa.pop_front()});
        got++;
        a_oe = 1'b0;
      end else if (!a_oe && !a_of && !a_ot && ($urandom % 4 != 0)) begin
        a_oe = 1'b1;
      end
    end
  endtask

  task automatic snk_b(input int n);
    int got = 0;
    while (got < n) begin
      @(negedge clk);
      if (b_oe && (b_of || b_ot)) begin
        if (qb.size() == 0) chk3("R9 u1 unexpected token", {2'b0, b_ot}, 3'bxxx);
        else chk3("R9 u1 token order", {2'b0, b_ot}, {2'b0, qb.pop_front()});
        got++;
        b_oe = 1'b0;
      end else if (!b_oe && !b_of && !b_ot && ($urandom % 4 != 0)) begin
        b_oe = 1'b1;
      end
    end
  endtask

  initial begin
    // Reset with active inputs: R10, R5, R6
    a_it = 1'b1; a_oe = 1'b1;
    b_it = 1'b1; b_oe = 1'b1;
    cyc(3);
    chk3("R5 R10 u0 reset", {a_of, a_ot, a_ie}, 3'b001);
    chk3("R6 R10 u1 reset", {b_of, b_ot, b_ie}, 3'b101);
    rst = 1'b0;

    // R7: valid input held since reset must not transfer before priming
    cyc(3);
    chk3("R7 u0 unprimed hold", {a_of, a_ot, a_ie}, 3'b001);
    a_it = 1'b0;
    cyc(1);
    chk3("R7 u0 primed no data", {a_of, a_ot, a_ie}, 3'b001);
    a_it = 1'b1;
    cyc(1);
    chk3("R2 u0 one transfer", {a_of, a_ot, a_ie}, 3'b010);

    // R3: input neutral alone is not enough
    a_it = 1'b0;
    cyc(2);
    chk3("R3 u0 no early return", {a_of, a_ot, a_ie}, 3'b010);
    a_oe = 1'b0;
    cyc(1);
    chk3("R3 u0 joint return", {a_of, a_ot, a_ie}, 3'b001);

    // R8: illegal code holds the empty stage
    a_oe = 1'b1; a_if = 1'b1; a_it = 1'b1;
    cyc(3);
    chk3("R8 u0 illegal hold", {a_of, a_ot, a_ie}, 3'b001);
    a_it = 1'b0;
    cyc(1);
    chk3("R2 u0 zero transfer", {a_of, a_ot, a_ie}, 3'b100);
    a_if = 1'b0; a_oe = 1'b0;
    cyc(1);
    chk3("R3 u0 return after zero", {a_of, a_ot, a_ie}, 3'b001);

    // R4: token stage blocks a new transfer while full
    chk3("R4 u1 full blocks transfer", {b_of, b_ot, b_ie}, 3'b101);
    b_oe = 1'b0;
    cyc(1);
    chk3("R4 u1 output drains alone", {b_of, b_ot, b_ie}, 3'b001);
    b_oe = 1'b1;
    cyc(1);
    chk3("R2 u1 one transfer", {b_of, b_ot, b_ie}, 3'b010);
    b_oe = 1'b0;
    cyc(1);
    chk3("R4 u1 drain with input valid", {b_of, b_ot, b_ie}, 3'b000);
    b_it = 1'b0;
    cyc(1);
    chk3("R4 u1 reopen alone", {b_of, b_ot, b_ie}, 3'b001);
    b_oe = 1'b1; b_if = 1'b1;
    cyc(1);
    chk3("R2 u1 zero transfer", {b_of, b_ot, b_ie}, 3'b100);
    b_it = 1'b1; b_oe = 1'b0;
    cyc(2);
    chk3("R8 u1 illegal hold", {b_of, b_ot, b_ie}, 3'b100);
    b_if = 1'b0; b_it = 1'b0;
    cyc(1);
    chk3("R4 u1 both branches", {b_of, b_ot, b_ie}, 3'b001);

    // R9: random streaming from a fresh reset
    rst = 1'b1;
    a_if = 1'b0; a_it = 1'b0; a_oe = 1'b1;
    b_if = 1'b0; b_it = 1'b0; b_oe = 1'b1;
    cyc(2);
    rst = 1'b0;
    qb.push_back(1'b0);
    fork
      src_a(NTOK);
      snk_a(NTOK);
      src_b(NTOK);
      snk_b(NTOK + 1);
    join
    chk3("R9 u0 all delivered", 3'(qa.size()), 3'd0);
    chk3("R9 u1 all delivered", 3'(qb.size()), 3'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule